// File: doc/BRIEF.md
# NAND Copy-Back Block Mover

This block sits above a NAND command sequencer. It moves the contents of one erase block into another, page by page, using the on-die copy-back command pair, so page data never crosses the flash bus. For each page it issues a copy-back read of the source page, then a copy-back program of the destination page, and inspects the status of the program. A page whose program fails is retried from the read phase, up to a fixed number of attempts. A single-page copy, a page program and a block erase can also be requested, and they follow the same retry rule.

A request is presented with a one-cycle `start` while the block is idle. The block checks the request for legality in that same cycle. An illegal request is answered at once with an error and sends nothing to the sequencer. A legal request runs on its own until it finishes. It then raises `done` for exactly one cycle, together with a result code. The sequencer is modelled as a request/acknowledge pair. The mover holds `seq_req` and a stable command description until the sequencer pulses `seq_ack`, which carries `seq_fail` when the chip status reports an error.

Top module: `nand_blkmover`

## Requirements
- R1: The read phase of a page copy is a command with first byte 0x00, second byte 0x35, five address cycles, row of the source page, no status check and no host data.
- R2: The program phase of a page copy is a command with first byte 0x85, second byte 0x10, five address cycles, row of the destination page, status check on and no host data.
- R3: Every row sent to the sequencer equals block number times `pages_per_blk` plus the page index.
- R4: A page-copy request (op 1) whose source and destination page indices differ in bit 0 ends with `done` in the cycle after `start` and error code 2 (illegal), and issues no sequencer command.
- R5: A block copy (op 0) with equal source and destination blocks, any request with `pages_per_blk` equal to 0 or above 2^PAGE_W, and a page copy or program whose page index is not below `pages_per_blk`, are each rejected like R4 with code 2.
- R6: A page copy, page program or erase is attempted at most MAX_TRIES (2) times. A failed page-copy attempt restarts at the read phase. When every attempt fails, the result is code 1 (bad block).
- R7: A block copy visits pages 0 up to `pages_per_blk`-1 in increasing order, using the same index in both blocks and showing it on `cur_page`. It stops with code 1 at the first page that exhausts its attempts.
- R8: A program request (op 2) issues 0x80 then 0x10 with five address cycles, host data enabled and status check. An erase request (op 3) issues 0x60 then 0xD0 with three address cycles and the row of page 0 of the block, with status check.
- R9: `done` is a single-cycle pulse. `err` gives the result (0 ok, 1 bad block, 2 illegal) from the `done` cycle until the next `done`. A request whose commands all pass returns 0, and its retry count starts afresh on every new page.
- R10: `seq_fail` returned for a read phase has no effect on the outcome or on the command stream.
- R11: `seq_req` and its command fields stay stable until `seq_ack`, and `seq_req` is low in the cycle after every `seq_ack`. A `start` raised while `busy` is high is ignored.
- R12: After reset, `busy`, `done`, `seq_req`, `err` and `cur_page` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | 0 block copy, 1 page copy, 2 page program, 3 block erase |
| src_blk | input | BLK_W | Source block number (copies) |
| dst_blk | input | BLK_W | Destination block number, or target block of program and erase |
| src_page | input | PAGE_W | Source page index (page copy) |
| dst_page | input | PAGE_W | Destination page index (page copy, program) |
| pages_per_blk | input | PAGE_W+1 | Pages in one erase block |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code of the last request |
| cur_page | output | PAGE_W | Page index being worked on |
| seq_req | output | 1 | Command request to the sequencer |
| seq_cmd1 | output | 8 | First command byte |
| seq_cmd2 | output | 8 | Second command byte |
| seq_naddr | output | 3 | Number of address cycles |
| seq_row | output | BLK_W+PAGE_W+1 | Row address, column is always zero |
| seq_chk_status | output | 1 | Sequencer reads status after ready and reports it |
| seq_wdata | output | 1 | Host data is written between the two command bytes |
| seq_ack | input | 1 | One-cycle completion pulse from the sequencer |
| seq_fail | input | 1 | Status failure, valid with `seq_ack` |

## Verification
The assertions assume that the sequencer pulses `seq_ack` for one cycle, and only while `seq_req` is high. They also assume that `start` stays low during reset, and that `seq_fail` carries meaning only alongside `seq_ack`. The bench sequencer model answers each request once, after a random delay of a few cycles. It drops the acknowledge on the next falling edge. Its failure answers come from a deterministic pattern, so a reference walk of the requirements can rebuild the exact command stream and result code.

// File: rtl/nand_mv_pkg.sv
package nand_mv_pkg;

  typedef enum logic [1:0] {
    OP_BLKCOPY = 2'd0,
    OP_PGCOPY  = 2'd1,
    OP_PROG    = 2'd2,
    OP_ERASE   = 2'd3
  } mv_op_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_BAD     = 2'd1,
    RES_ILLEGAL = 2'd2
  } mv_res_e;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } mv_phase_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_GAP   = 2'd2
  } mv_state_e;

  typedef struct packed {
    logic [7:0] c1;
    logic [7:0] c2;
    logic [2:0] naddr;
    logic       chk;
    logic       wdata;
  } seq_cmd_t;

  localparam logic [7:0] CB_RD_A  = 8'h00;
  localparam logic [7:0] CB_RD_B  = 8'h35;
  localparam logic [7:0] CB_PG_A  = 8'h85;
  localparam logic [7:0] CB_PG_B  = 8'h10;
  localparam logic [7:0] PG_A     = 8'h80;
  localparam logic [7:0] PG_B     = 8'h10;
  localparam logic [7:0] ER_A     = 8'h60;
  localparam logic [7:0] ER_B     = 8'hD0;
  localparam logic [2:0] ADDR_LONG  = 3'd5;
  localparam logic [2:0] ADDR_SHORT = 3'd3;

endpackage

// File: rtl/nand_row_calc.sv
module nand_row_calc #(
  parameter int BLK_W  = 10,
  parameter int PAGE_W = 6,
  localparam int ROW_W = BLK_W + PAGE_W + 1,
  localparam int PPB_W = PAGE_W + 1
) (
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PPB_W-1:0]  ppb_i,
  output logic [ROW_W-1:0]  row_o
);

  logic [ROW_W-1:0] blk_x;
  logic [ROW_W-1:0] ppb_x;
  logic [ROW_W-1:0] page_x;

  always_comb begin
    blk_x  = {{(ROW_W-BLK_W){1'b0}}, blk_i};
    ppb_x  = {{(ROW_W-PPB_W){1'b0}}, ppb_i};
    page_x = {{(ROW_W-PAGE_W){1'b0}}, page_i};
    row_o  = (blk_x * ppb_x) + page_x;
  end

endmodule

// File: rtl/nand_retry_ctr.sv
module nand_retry_ctr #(
  parameter int MAX_TRIES = 2,
  localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic bump_i,
  output logic last_o
);

  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      tries_q <= '0;
    end else if (bump_i && !last_o) begin
      tries_q <= tries_q + TW'(1);
    end
  end

  assign last_o = (tries_q == TW'(MAX_TRIES - 1));

endmodule

// File: rtl/nand_cmd_sel.sv
module nand_cmd_sel
  import nand_mv_pkg::*;
(
  input  mv_op_e    op_i,
  input  mv_phase_e phase_i,
  output seq_cmd_t  cmd_o
);

  always_comb begin
    cmd_o = '0;
    unique case (op_i)
      OP_BLKCOPY, OP_PGCOPY: begin
        if (phase_i == PH_READ) begin
          cmd_o = '{c1: CB_RD_A, c2: CB_RD_B, naddr: ADDR_LONG, chk: 1'b0, wdata: 1'b0};
        end else begin
          cmd_o = '{c1: CB_PG_A, c2: CB_PG_B, naddr: ADDR_LONG, chk: 1'b1, wdata: 1'b0};
        end
      end
      OP_PROG: begin
        cmd_o = '{c1: PG_A, c2: PG_B, naddr: ADDR_LONG, chk: 1'b1, wdata: 1'b1};
      end
      OP_ERASE: begin
        cmd_o = '{c1: ER_A, c2: ER_B, naddr: ADDR_SHORT, chk: 1'b1, wdata: 1'b0};
      end
      default: cmd_o = '0;
    endcase
  end

endmodule

// File: rtl/nand_req_check.sv
module nand_req_check
  import nand_mv_pkg::*;
#(
  parameter int BLK_W  = 10,
  parameter int PAGE_W = 6,
  localparam int PPB_W = PAGE_W + 1,
  localparam int PAGES_MAX = 2 ** PAGE_W
) (
  input  mv_op_e            op_i,
  input  logic [BLK_W-1:0]  src_blk_i,
  input  logic [BLK_W-1:0]  dst_blk_i,
  input  logic [PAGE_W-1:0] src_page_i,
  input  logic [PAGE_W-1:0] dst_page_i,
  input  logic [PPB_W-1:0]  ppb_i,
  output logic              illegal_o
);

  logic geom_bad;
  logic src_out;
  logic dst_out;
  logic parity_bad;

  always_comb begin
    geom_bad   = (ppb_i == '0) || (ppb_i > PPB_W'(PAGES_MAX));
    src_out    = ({1'b0, src_page_i} >= ppb_i);
    dst_out    = ({1'b0, dst_page_i} >= ppb_i);
    parity_bad = (src_page_i[0] != dst_page_i[0]);
    illegal_o  = geom_bad;
    unique case (op_i)
      OP_BLKCOPY: illegal_o = geom_bad || (src_blk_i == dst_blk_i);
      OP_PGCOPY:  illegal_o = geom_bad || parity_bad || src_out || dst_out;
      OP_PROG:    illegal_o = geom_bad || dst_out;
      OP_ERASE:   illegal_o = geom_bad;
      default:    illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/nand_blkmover.sv
module nand_blkmover
  import nand_mv_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int PAGE_W    = 6,
  parameter int MAX_TRIES = 2,
  localparam int ROW_W = BLK_W + PAGE_W + 1,
  localparam int PPB_W = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [BLK_W-1:0]  src_blk,
  input  logic [BLK_W-1:0]  dst_blk,
  input  logic [PAGE_W-1:0] src_page,
  input  logic [PAGE_W-1:0] dst_page,
  input  logic [PPB_W-1:0]  pages_per_blk,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic [PAGE_W-1:0] cur_page,
  output logic              seq_req,
  output logic [7:0]        seq_cmd1,
  output logic [7:0]        seq_cmd2,
  output logic [2:0]        seq_naddr,
  output logic [ROW_W-1:0]  seq_row,
  output logic              seq_chk_status,
  output logic              seq_wdata,
  input  logic              seq_ack,
  input  logic              seq_fail
);

  mv_state_e         state_q;
  mv_op_e            op_q;
  mv_phase_e         phase_q;
  mv_res_e           res_q;
  logic [BLK_W-1:0]  src_blk_q;
  logic [BLK_W-1:0]  dst_blk_q;
  logic [PAGE_W-1:0] src_pg_q;
  logic [PAGE_W-1:0] pg_q;
  logic [PPB_W-1:0]  ppb_q;
  logic              done_q;

  logic              illegal;
  logic              accept;
  logic              wr_ack;
  logic              try_last;
  logic              try_clr;
  logic              try_bump;
  logic              last_page;
  logic [BLK_W-1:0]  row_blk;
  logic [PAGE_W-1:0] row_pg;
  seq_cmd_t          cmd;

  nand_req_check #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_check (
    .op_i       (mv_op_e'(op)),
    .src_blk_i  (src_blk),
    .dst_blk_i  (dst_blk),
    .src_page_i (src_page),
    .dst_page_i (dst_page),
    .ppb_i      (pages_per_blk),
    .illegal_o  (illegal)
  );

  assign accept    = (state_q == S_IDLE) && start;
  assign wr_ack    = (state_q == S_ISSUE) && seq_ack && (phase_q == PH_WRITE);
  assign try_clr   = accept || (wr_ack && !seq_fail);
  assign try_bump  = wr_ack && seq_fail;
  assign last_page = ({1'b0, pg_q} == (ppb_q - PPB_W'(1)));

  nand_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (try_clr),
    .bump_i (try_bump),
    .last_o (try_last)
  );

  always_comb begin
    if (phase_q == PH_READ) begin
      row_blk = src_blk_q;
      row_pg  = (op_q == OP_BLKCOPY) ? pg_q : src_pg_q;
    end else begin
      row_blk = dst_blk_q;
      row_pg  = pg_q;
    end
  end

  nand_row_calc #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_row (
    .blk_i  (row_blk),
    .page_i (row_pg),
    .ppb_i  (ppb_q),
    .row_o  (seq_row)
  );

  nand_cmd_sel u_cmd (
    .op_i    (op_q),
    .phase_i (phase_q),
    .cmd_o   (cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      op_q      <= OP_BLKCOPY;
      phase_q   <= PH_READ;
      res_q     <= RES_OK;
      src_blk_q <= '0;
      dst_blk_q <= '0;
      src_pg_q  <= '0;
      pg_q      <= '0;
      ppb_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            if (illegal) begin
              done_q <= 1'b1;
              res_q  <= RES_ILLEGAL;
            end else begin
              state_q   <= S_ISSUE;
              op_q      <= mv_op_e'(op);
              src_blk_q <= src_blk;
              dst_blk_q <= dst_blk;
              src_pg_q  <= src_page;
              ppb_q     <= pages_per_blk;
              if ((mv_op_e'(op) == OP_BLKCOPY) || (mv_op_e'(op) == OP_ERASE)) begin
                pg_q <= '0;
              end else begin
                pg_q <= dst_page;
              end
              if ((mv_op_e'(op) == OP_BLKCOPY) || (mv_op_e'(op) == OP_PGCOPY)) begin
                phase_q <= PH_READ;
              end else begin
                phase_q <= PH_WRITE;
              end
            end
          end
        end
        S_ISSUE: begin
          if (seq_ack) begin
            if (phase_q == PH_READ) begin
              phase_q <= PH_WRITE;
              state_q <= S_GAP;
            end else if (seq_fail) begin
              if (try_last) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
                res_q   <= RES_BAD;
              end else begin
                state_q <= S_GAP;
                if ((op_q == OP_BLKCOPY) || (op_q == OP_PGCOPY)) begin
                  phase_q <= PH_READ;
                end
              end
            end else if ((op_q == OP_BLKCOPY) && !last_page) begin
              pg_q    <= pg_q + PAGE_W'(1);
              phase_q <= PH_READ;
              state_q <= S_GAP;
            end else begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              res_q   <= RES_OK;
            end
          end
        end
        S_GAP: begin
          state_q <= S_ISSUE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state_q != S_IDLE);
  assign done           = done_q;
  assign err            = res_q;
  assign cur_page       = pg_q;
  assign seq_req        = (state_q == S_ISSUE);
  assign seq_cmd1       = cmd.c1;
  assign seq_cmd2       = cmd.c2;
  assign seq_naddr      = cmd.naddr;
  assign seq_chk_status = cmd.chk;
  assign seq_wdata      = cmd.wdata;

endmodule

// File: rtl/nand_blkmover_chk.sv
module nand_blkmover_chk #(
  parameter int PAGE_W = 6,
  parameter int ROW_W  = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err,
  input logic [PAGE_W-1:0] cur_page,
  input logic              seq_req,
  input logic              seq_ack,
  input logic [7:0]        seq_cmd1,
  input logic [ROW_W-1:0]  seq_row
);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_gap_after_ack_R11: assert property (@(posedge clk) disable iff (rst)
    seq_ack |=> !seq_req);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (seq_req && !seq_ack) |=> (seq_req && $stable(seq_row) && $stable(seq_cmd1)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !seq_req);

  assert_illegal_now_R4: assert property (@(posedge clk) disable iff (rst)
    (done && (err == 2'd2)) |-> $past(start && !busy));

  assert_page_order_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (cur_page != $past(cur_page)))
      |-> (cur_page == $past(cur_page) + PAGE_W'(1)));

endmodule

bind nand_blkmover nand_blkmover_chk #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .cur_page (cur_page),
  .seq_req  (seq_req),
  .seq_ack  (seq_ack),
  .seq_cmd1 (seq_cmd1),
  .seq_row  (seq_row)
);

// File: tb/tb_nand_blkmover.sv
module tb_nand_blkmover;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 6;
  localparam int PW = 4;
  localparam int RW = BW + PW + 1;
  localparam int EW = 8 + 8 + 3 + 1 + 1 + RW + PW;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [1:0] op;
  logic [BW-1:0] src_blk, dst_blk;
  logic [PW-1:0] src_page, dst_page;
  logic [PW:0] ppb;
  logic busy, done;
  logic [1:0] err;
  logic [PW-1:0] cur_page;
  logic seq_req, seq_chk_status, seq_wdata, seq_ack, seq_fail;
  logic [7:0] seq_cmd1, seq_cmd2;
  logic [2:0] seq_naddr;
  logic [RW-1:0] seq_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_blkmover #(.BLK_W(BW), .PAGE_W(PW), .MAX_TRIES(2)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .src_blk(src_blk), .dst_blk(dst_blk), .src_page(src_page), .dst_page(dst_page),
    .pages_per_blk(ppb), .busy(busy), .done(done), .err(err), .cur_page(cur_page),
    .seq_req(seq_req), .seq_cmd1(seq_cmd1), .seq_cmd2(seq_cmd2), .seq_naddr(seq_naddr),
    .seq_row(seq_row), .seq_chk_status(seq_chk_status), .seq_wdata(seq_wdata),
    .seq_ack(seq_ack), .seq_fail(seq_fail)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [EW-1:0] exp_e [DEPTH];
  logic [EW-1:0] log_e [DEPTH];
  int exp_n, log_n, mdl_n;
  logic [1:0] exp_err;
  logic [31:0] force_mask;
  int fail_pct;
  logic [31:0] fail_salt;

  function automatic logic [EW-1:0] pack(logic [7:0] c1, logic [7:0] c2, logic [2:0] na,
                                         logic ck, logic wd, logic [RW-1:0] row, logic [PW-1:0] pg);
    return {c1, c2, na, ck, wd, row, pg};
  endfunction

  function automatic logic fail_of(int n);
    logic [31:0] h;
    h = (32'(n) + fail_salt) * 32'd2654435761;
    return ((n < 32) && force_mask[n]) || ((32'(h[23:16]) % 100) < 32'(fail_pct));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] c1, logic [7:0] c2, logic [2:0] na, logic ck, logic wd,
                      int row, int pg);
    if (exp_n < DEPTH) exp_e[exp_n] = pack(c1, c2, na, ck, wd, RW'(row), PW'(pg));
    exp_n++;
  endtask

  // Reference walk built from the requirements only
  task automatic build_exp(int o, int sb, int db, int sp, int dp, int pp);
    int n;
    bit ok, bad;
    exp_n = 0;
    n = 0;
    bad = (pp == 0) || (pp > 16) ||
          ((o == 0) && (sb == db)) ||
          ((o == 1) && (((sp % 2) != (dp % 2)) || (sp >= pp) || (dp >= pp))) ||
          ((o == 2) && (dp >= pp));
    if (bad) begin
      exp_err = 2'd2;
      return;
    end
    exp_err = 2'd0;
    if (o == 0 || o == 1) begin
      for (int p = 0; p < ((o == 0) ? pp : 1); p++) begin
        int rp, wp;
        rp = (o == 0) ? p : sp;
        wp = (o == 0) ? p : dp;
        ok = 1'b0;
        for (int a = 0; a < 2; a++) begin
          push(8'h00, 8'h35, 3'd5, 1'b0, 1'b0, sb * pp + rp, wp);
          n++;
          push(8'h85, 8'h10, 3'd5, 1'b1, 1'b0, db * pp + wp, wp);
          if (!fail_of(n)) ok = 1'b1;
          n++;
          if (ok) break;
        end
        if (!ok) begin
          exp_err = 2'd1;
          return;
        end
      end
    end else begin
      ok = 1'b0;
      for (int a = 0; a < 2; a++) begin
        if (o == 2) push(8'h80, 8'h10, 3'd5, 1'b1, 1'b1, db * pp + dp, dp);
        else        push(8'h60, 8'hD0, 3'd3, 1'b1, 1'b0, db * pp, 0);
        if (!fail_of(n)) ok = 1'b1;
        n++;
        if (ok) break;
      end
      if (!ok) exp_err = 2'd1;
    end
  endtask

  // Sequencer model
  initial begin
    bit pend;
    bit fl;
    int lat;
    pend = 1'b0;
    fl = 1'b0;
    lat = 0;
    seq_ack = 1'b0;
    seq_fail = 1'b0;
    forever begin
      @(negedge clk);
      if (seq_ack) begin
        seq_ack = 1'b0;
        seq_fail = 1'b0;
      end else if (seq_req && !pend) begin
        if (log_n < DEPTH)
          log_e[log_n] = pack(seq_cmd1, seq_cmd2, seq_naddr, seq_chk_status, seq_wdata, seq_row, cur_page);
        log_n++;
        fl = fail_of(mdl_n);
        mdl_n++;
        lat = $urandom_range(0, 3);
        pend = 1'b1;
      end else if (pend) begin
        if (lat == 0) begin
          seq_ack = 1'b1;
          seq_fail = fl;
          pend = 1'b0;
        end else begin
          lat--;
        end
      end
    end
  end

  task automatic run_op(int o, int sb, int db, int sp, int dp, int pp, bit poke, string tag);
    int cyc;
    build_exp(o, sb, db, sp, dp, pp);
    log_n = 0;
    mdl_n = 0;
    @(negedge clk);
    op = 2'(o); src_blk = BW'(sb); dst_blk = BW'(db);
    src_page = PW'(sp); dst_page = PW'(dp); ppb = 5'(pp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      if (poke && cyc == 3) begin
        start = 1'b1;
        op = 2'd3;
        dst_blk = BW'(db + 1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, tag, "done seen", done, 1);
    chk(err == exp_err, tag, "result code", err, exp_err);
    if (exp_err == 2'd2) chk(cyc == 0, "R4", "illegal latency", cyc, 0);
    @(negedge clk);
    chk(!done, "R9", "done pulse width", done, 0);
    chk(log_n == exp_n, tag, "command count", log_n, exp_n);
    if (log_n == exp_n) begin
      for (int i = 0; i < exp_n && i < DEPTH; i++) begin
        string t;
        logic [EW-1:0] x;
        x = exp_e[i];
        if (log_e[i][RW+PW-1:PW] != x[RW+PW-1:PW]) t = "R3";
        else if (log_e[i][PW-1:0] != x[PW-1:0]) t = "R7";
        else if (x[EW-1:EW-8] == 8'h00) t = "R1";
        else if (x[EW-1:EW-8] == 8'h85) t = "R2";
        else t = "R8";
        chk(log_e[i] == x, t, "command entry", log_e[i], x);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240607);
    rst = 1'b1; start = 1'b0; op = '0; src_blk = '0; dst_blk = '0;
    src_page = '0; dst_page = '0; ppb = '0;
    force_mask = '0; fail_pct = 0; fail_salt = '0;
    log_n = 0; mdl_n = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !seq_req && err == 2'd0 && cur_page == '0, "R12", "reset state",
        {busy, done, seq_req, err, cur_page}, 0);

    // Directed cases
    run_op(3, 5, 5, 0, 0, 8, 1'b0, "R8");                 // erase
    run_op(2, 0, 3, 0, 7, 8, 1'b0, "R8");                 // program
    force_mask = 32'h3;
    run_op(2, 0, 4, 0, 2, 8, 1'b0, "R6");                 // program fails twice
    force_mask = 32'h0;
    run_op(1, 9, 10, 2, 6, 8, 1'b0, "R2");                // page copy
    force_mask = 32'h1;
    run_op(1, 9, 10, 3, 5, 8, 1'b0, "R10");               // read fail flag ignored
    force_mask = 32'h2;
    run_op(1, 11, 12, 0, 4, 8, 1'b0, "R6");               // one retry from read phase
    force_mask = 32'h0;
    run_op(0, 1, 2, 0, 0, 4, 1'b0, "R7");                 // block copy
    force_mask = 32'h28;
    run_op(0, 3, 7, 0, 0, 4, 1'b0, "R7");                 // abort at page 1
    force_mask = 32'h0;
    run_op(1, 1, 2, 1, 2, 8, 1'b0, "R4");                 // parity mismatch
    run_op(0, 6, 6, 0, 0, 8, 1'b0, "R5");                 // same block
    run_op(3, 0, 6, 0, 0, 0, 1'b0, "R5");                 // zero pages per block
    run_op(3, 0, 6, 0, 0, 17, 1'b0, "R5");                // too many pages
    run_op(2, 0, 6, 0, 8, 8, 1'b0, "R5");                 // page out of range
    run_op(0, 63, 0, 0, 0, 16, 1'b0, "R3");               // widest rows
    run_op(0, 20, 21, 0, 0, 3, 1'b1, "R11");              // start while busy

    // Random mix with deterministic sequencer failures
    fail_pct = 30;
    for (int k = 0; k < 40; k++) begin
      int o, sb, db, sp, dp, pp;
      fail_salt = $urandom;
      o  = $urandom_range(0, 3);
      sb = $urandom_range(0, 63);
      db = ($urandom_range(0, 7) == 0) ? sb : $urandom_range(0, 63);
      pp = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 31) : $urandom_range(1, 8);
      sp = $urandom_range(0, 15);
      dp = $urandom_range(0, 15);
      if (pp > 0 && pp <= 16 && $urandom_range(0, 3) != 0) begin
        sp = sp % pp;
        dp = dp % pp;
      end
      run_op(o, sb, db, sp, dp, pp, 1'b0, "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule